// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Sequencer

This block sequences the addresses and counts of one DMA channel. A small slot RAM holds descriptors of eight 32-bit words each. Slot 0 is the working descriptor of the channel. Each trigger event makes the block walk part of a three-level transfer. The inner level is an array of A bytes, the middle level is a frame of B arrays, and the outer level is a block of C frames. For each array the block raises a request toward a memory mover, carrying a source address, a destination address and a byte count, and holds it until the mover acknowledges it.

Software fills the slots through a simple write port. Once the last array of a descriptor has been moved, the block does one of two things: it reloads slot 0 from the slot named in the link field, or it disarms the channel. Completion pulses carry a 6-bit code and are gated by per-descriptor enable bits. A trigger that arrives while the channel is busy is held in a single pending bit. If a further trigger arrives while that bit is already set, a sticky flag records the lost event.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, all slots read as zero, `req_valid`, `missed` and every completion pulse are low, and a trigger raises no request.
- R2: Word layout of a slot: w0 options, w1 source, w2 {B count[31:16], A count[15:0]}, w3 destination, w4 {dst B stride[31:16], src B stride[15:0]}, w5 {B reload[31:16], link[15:0]}, w6 {dst C stride[31:16], src C stride[15:0]}, w7 C count[15:0]. It is written through `cfg_addr` = {slot, word[2:0]}. A request shows w1, w3 and the A count, and all three hold steady until `req_ack`.
- R3: With option bit 2 at 0, each trigger issues exactly one array request.
- R4: With option bit 2 at 1, each trigger issues the B requests of one frame in succession.
- R5: On an incrementing side (option bit 0 for source, bit 1 for destination, value 0), the next array of a frame starts at the previous address plus the signed B stride. The first array of the next frame starts at the first address of the current frame plus the signed C stride. When B runs out, it is reloaded from the B-reload field and C decrements. On a side whose bit is 1, the address stays constant.
- R6: One cycle after the acknowledge that ends a trigger's work, exactly one completion fires. It is final if that work included the last array of the descriptor and intermediate otherwise. `fin_irq`, `mid_irq`, `fin_chain` and `mid_chain` are gated by option bits 20, 21, 22 and 23. `done_code` shows option bits 17:12.
- R7: On final completion with a link value other than 0xFFFF, slot 0 is overwritten with slot (link mod SLOTS).
- R8: On final completion with link 0xFFFF, the A, B and C counts become zero, and later triggers raise no request.
- R9: With option bit 3 set, slot 0 is never updated or reloaded, so every trigger repeats the same array.
- R10: A trigger that arrives while the channel is busy sets a pending bit, and that bit starts the next piece of work once the channel is idle. A trigger that arrives while the channel is busy and the bit is already set raises `missed`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot RAM write strobe |
| cfg_addr | input | log2(SLOTS)+3 | {slot, word} write address |
| cfg_wdata | input | 32 | Write data |
| trig | input | 1 | Transfer event |
| req_valid | output | 1 | Array request pending |
| req_ack | input | 1 | Mover accepts the request |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_len | output | 16 | Array length in bytes |
| done_code | output | 6 | Completion code of the last completion |
| fin_irq | output | 1 | Final-completion interrupt pulse |
| mid_irq | output | 1 | Intermediate-completion interrupt pulse |
| fin_chain | output | 1 | Final-completion chain pulse |
| mid_chain | output | 1 | Intermediate-completion chain pulse |
| missed | output | 1 | Sticky lost-trigger flag |

## Verification
The bench sweeps every combination of sync mode, source and destination addressing mode, B count 1 to 3, C count 1 to 2 and B reload 1 or 3. It uses signed strides of both polarities, so the sweep separates a frame restart from the frame base from a plain B-stride step, and it exposes an off-by-one in the reload of the first frame compared with later frames. Enable bits and codes rotate across configurations, which tells the four pulse gates apart and checks which option word supplies them. Directed cases cover a link index above the slot count, a static descriptor that must repeat itself, and a burst of three triggers against an unacknowledged request, which tells the pending bit apart from the missed flag.

// File: rtl/dma_desc_seq.sv
module dma_desc_seq #(
  parameter int SLOTS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(SLOTS)+2:0]  cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic                      trig,
  output logic                      req_valid,
  input  logic                      req_ack,
  output logic [31:0]               req_src,
  output logic [31:0]               req_dst,
  output logic [15:0]               req_len,
  output logic [5:0]                done_code,
  output logic                      fin_irq,
  output logic                      mid_irq,
  output logic                      fin_chain,
  output logic                      mid_chain,
  output logic                      missed
);

  localparam int SW = $clog2(SLOTS);
  localparam int NW = SLOTS * 8;

  logic [31:0] ram [NW];
  logic        busy, pend, frm_first;
  logic [31:0] base_s, base_d;

  wire [31:0] opt  = ram[0];
  wire [31:0] src  = ram[1];
  wire [31:0] ab   = ram[2];
  wire [31:0] dst  = ram[3];
  wire [31:0] bidx = ram[4];
  wire [31:0] lnk  = ram[5];
  wire [31:0] cidx = ram[6];
  wire [31:0] cc   = ram[7];

  wire [15:0] acnt = ab[15:0];
  wire [15:0] bcnt = ab[31:16];
  wire [15:0] ccnt = cc[15:0];
  wire [SW-1:0] lidx = lnk[SW-1:0];

  logic unused_bits;
  assign unused_bits = ^{opt[31:24], opt[19:18], opt[11:4], cc[31:16]};

  wire armed    = (acnt != 0) && (bcnt != 0) && (ccnt != 0);
  wire go       = !busy && (trig || pend) && armed;
  wire fire     = busy && req_ack;
  wire frm_end  = bcnt <= 16'd1;
  wire last_all = frm_end && (ccnt <= 16'd1);
  wire trig_end = fire && (!opt[2] || frm_end);
  wire fin      = trig_end && last_all;
  wire mid      = trig_end && !last_all;
  wire null_lnk = lnk[15:0] == 16'hFFFF;

  wire [31:0] bs = frm_first ? src : base_s;
  wire [31:0] bd = frm_first ? dst : base_d;
  wire [31:0] nsrc = opt[0] ? src :
                     frm_end ? bs + {{16{cidx[15]}}, cidx[15:0]}
                             : src + {{16{bidx[15]}}, bidx[15:0]};
  wire [31:0] ndst = opt[1] ? dst :
                     frm_end ? bd + {{16{cidx[31]}}, cidx[31:16]}
                             : dst + {{16{bidx[31]}}, bidx[31:16]};
  wire [31:0] nab = frm_end ? {lnk[31:16], acnt} : {bcnt - 16'd1, acnt};
  wire [31:0] ncc = frm_end ? {16'h0, ccnt - 16'd1} : {16'h0, ccnt};

  assign req_valid = busy;
  assign req_src   = src;
  assign req_dst   = dst;
  assign req_len   = acnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) ram[i] <= '0;
    end else begin
      if (cfg_we) ram[cfg_addr] <= cfg_wdata;
      if (fire && !opt[3]) begin
        if (fin && !null_lnk) begin
          for (int w = 0; w < 8; w++) ram[w] <= ram[{lidx, 3'(w)}];
        end else begin
          ram[1] <= nsrc;
          ram[3] <= ndst;
          ram[2] <= fin ? 32'h0 : nab;
          ram[7] <= fin ? 32'h0 : ncc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      missed <= 1'b0;
      frm_first <= 1'b1;
      base_s <= '0;
      base_d <= '0;
    end else begin
      if (go) busy <= 1'b1;
      else if (trig_end) busy <= 1'b0;

      if (busy) begin
        if (trig) begin
          if (pend) missed <= 1'b1;
          pend <= 1'b1;
        end
      end else if (go) begin
        pend <= trig && pend;
      end else begin
        pend <= 1'b0;
      end

      if (fire) begin
        frm_first <= frm_end;
        if (frm_first) begin
          base_s <= src;
          base_d <= dst;
        end
      end else if (cfg_we && cfg_addr[SW+2:3] == '0 &&
                   (cfg_addr[2:0] == 3'd1 || cfg_addr[2:0] == 3'd3)) begin
        frm_first <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_irq <= 1'b0;
      mid_irq <= 1'b0;
      fin_chain <= 1'b0;
      mid_chain <= 1'b0;
      done_code <= '0;
    end else begin
      fin_irq   <= fin & opt[20];
      mid_irq   <= mid & opt[21];
      fin_chain <= fin & opt[22];
      mid_chain <= mid & opt[23];
      if (trig_end) done_code <= opt[17:12];
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_ack && !cfg_we |=> req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_len)); // R2
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> missed); // R10
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((fin_irq || fin_chain) && (mid_irq || mid_chain))); // R6
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_irq || mid_irq || fin_chain || mid_chain) |-> $past(req_valid && req_ack)); // R6
  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !armed |=> !req_valid); // R8

endmodule

// File: tb/test_dma_desc_seq.sv
module test_dma_desc_seq;
  localparam int SLOTS = 8;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic trig = 0, req_ack = 0;
  logic req_valid, fin_irq, mid_irq, fin_chain, mid_chain, missed;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_len;
  logic [5:0] done_code;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dma_desc_seq #(.SLOTS(SLOTS)) i_dma_desc_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig(trig), .req_valid(req_valid),
    .req_ack(req_ack), .req_src(req_src), .req_dst(req_dst),
    .req_len(req_len), .done_code(done_code), .fin_irq(fin_irq),
    .mid_irq(mid_irq), .fin_chain(fin_chain), .mid_chain(mid_chain),
    .missed(missed));

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int slot, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(slot * 8 + word); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_desc(input int slot, input logic [31:0] opt, input logic [31:0] s,
                         input logic [31:0] d, input int a, input int b, input int br,
                         input int c, input int bis, input int bid, input int cis,
                         input int cid, input int lk);
    wr(slot, 0, opt);
    wr(slot, 1, s);
    wr(slot, 2, {16'(b), 16'(a)});
    wr(slot, 3, d);
    wr(slot, 4, {16'(bid), 16'(bis)});
    wr(slot, 5, {16'(br), 16'(lk)});
    wr(slot, 6, {16'(cid), 16'(cis)});
    wr(slot, 7, 32'(c));
  endtask

  task automatic pulse_trig();
    trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic ack();
    req_ack = 1;
    @(negedge clk);
    req_ack = 0;
  endtask

  task automatic expect_idle(input string r);
    pulse_trig();
    chk(!req_valid, r, 64'(req_valid), 64'd0);
    @(negedge clk);
    chk(!req_valid, r, 64'(req_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!req_valid && !missed && !fin_irq && !mid_irq && !fin_chain && !mid_chain,
        "R1", {58'd0, req_valid, missed, fin_irq, mid_irq, fin_chain, mid_chain}, 64'd0);
    expect_idle("R1");

    // R3 R4 R5 R6 R8 sweep
    idx = 0;
    for (int sy = 0; sy < 2; sy++)
      for (int sm = 0; sm < 2; sm++)
        for (int dm = 0; dm < 2; dm++)
          for (int b = 1; b <= 3; b++)
            for (int c = 1; c <= 2; c++)
              for (int bri = 0; bri < 2; bri++) begin
                int br, bis, bid, cis, cid, a;
                logic [3:0] en;
                logic [5:0] code;
                logic [31:0] s0, d0, opt;
                br = bri ? 3 : 1;
                a = 4 + idx % 5;
                bis = b * 7 - 10; bid = 12 - b * 5;
                cis = 3 - c * 40; cid = c * 33;
                en = 4'(idx); code = 6'(idx * 5);
                s0 = 32'h1000 + 32'(idx * 256); d0 = 32'h8000_0000 - 32'(idx * 512);
                opt = {8'h0, en, 2'b0, code, 1'b0, 3'b010, 4'b0, 1'b0, 1'(sy), 1'(dm), 1'(sm)};
                wr_desc(0, opt, s0, d0, a, b, br, c, bis, bid, cis, cid, 16'hFFFF);
                for (int k = 0; k < c; k++) begin
                  int nb;
                  nb = (k == 0) ? b : br;
                  for (int j = 0; j < nb; j++) begin
                    logic [31:0] es, ed;
                    bit last, tend;
                    last = (k == c - 1) && (j == nb - 1);
                    tend = (sy == 0) || (j == nb - 1);
                    es = sm ? s0 : s0 + 32'(k * cis) + 32'(j * bis);
                    ed = dm ? d0 : d0 + 32'(k * cid) + 32'(j * bid);
                    if (sy == 0 || j == 0) pulse_trig();
                    chk(req_valid && req_src == es && req_dst == ed && req_len == 16'(a),
                        sy ? "R4 R5 array" : "R3 R5 array", {req_src, req_dst}, {es, ed});
                    ack();
                    chk(fin_irq == (last & en[0]) && mid_irq == (tend & !last & en[1]) &&
                        fin_chain == (last & en[2]) && mid_chain == (tend & !last & en[3]),
                        "R6 pulses", {60'd0, fin_irq, mid_irq, fin_chain, mid_chain},
                        {60'd0, 1'(last & en[0]), 1'(tend & !last & en[1]),
                         1'(last & en[2]), 1'(tend & !last & en[3])});
                    if (tend) chk(done_code == code, "R6 code", 64'(done_code), 64'(code));
                    if (!tend) chk(req_valid, "R4 frame continues", 64'(req_valid), 64'd1);
                  end
                end
                expect_idle("R8 null link");
                idx++;
              end

    // R7 link, index above slot count wraps to slot 3
    wr_desc(3, 32'h0010_0000, 32'hA000, 32'hB000, 8, 1, 1, 1, 0, 0, 0, 0, 16'hFFFF);
    wr_desc(0, 32'h0010_0000, 32'h100, 32'h200, 4, 1, 1, 1, 0, 0, 0, 0, 11);
    pulse_trig();
    chk(req_valid && req_src == 32'h100, "R7 first", 64'(req_src), 64'h100);
    ack();
    chk(fin_irq, "R7 final", 64'(fin_irq), 64'd1);
    pulse_trig();
    chk(req_valid && req_src == 32'hA000 && req_dst == 32'hB000 && req_len == 16'd8,
        "R7 linked", {req_src, req_dst}, {32'hA000, 32'hB000});
    ack();
    expect_idle("R7 R8 after link");

    // R9 static descriptor repeats
    wr_desc(0, 32'h0020_0008, 32'h300, 32'h400, 4, 2, 2, 2, 4, 4, 64, 64, 16'hFFFF);
    for (int t = 0; t < 3; t++) begin
      pulse_trig();
      chk(req_valid && req_src == 32'h300 && req_dst == 32'h400, "R9 static",
          {req_src, req_dst}, {32'h300, 32'h400});
      ack();
      chk(mid_irq && !fin_irq, "R9 mid", {62'd0, mid_irq, fin_irq}, 64'd2);
    end

    // R10 pending and missed
    wr_desc(0, 32'h0020_0000, 32'h1000, 32'h2000, 4, 3, 3, 1, 16, 16, 0, 0, 16'hFFFF);
    chk(!missed, "R10 clear", 64'(missed), 64'd0);
    trig = 1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    trig = 0;
    chk(missed, "R10 missed", 64'(missed), 64'd1);
    chk(req_valid && req_src == 32'h1000, "R10 held", 64'(req_src), 64'h1000);
    ack();
    chk(!req_valid && mid_irq, "R10 done", {62'd0, req_valid, mid_irq}, 64'd1);
    @(negedge clk);
    chk(req_valid && req_src == 32'h1010, "R10 pending start", 64'(req_src), 64'h1010);
    ack();
    @(negedge clk);
    @(negedge clk);
    chk(!req_valid && missed, "R10 one pending only", {62'd0, req_valid, missed}, 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule